// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block is a two-channel DMA engine that moves one unit of data for each request it accepts. Each move borrows the memory bus for two consecutive cycles: a read from the source address, then a write of the captured data to the destination address. Between moves the bus is released, so the processor keeps most of the bandwidth.

Each channel holds a programmed source start, a destination start, a reload value for its 16-bit transfer counter, and a working counter and pointer. A control word chooses enable, 8-bit or 16-bit units, which side (if any) advances through memory, single or repeat operation, and which hardware event raises a request. A request comes from an edge on the channel's external pin (falling only, or both edges), from a one-cycle peripheral strobe, or from a software trigger write. When a channel's counter runs out, the block emits a one-cycle interrupt pulse for that channel.

Software programs a channel through a small write port addressed by channel and register select. The same channel and select address a combinational read-back port. Registers are control (select 0), source start (1), destination start (2), reload (3), current counter (4, read only), software trigger (5, write only) and working pointer (6, read only).

Top module: `dmaCycleSteal`

## Requirements
- R1: When both channels hold a serviceable request while the bus is idle, channel 0 is served first and channel 1 is served after it.
- R2: Control bit 1 selects 16-bit units. With it set, memWide is 1 for the read and the write, two bytes move, and an advancing pointer steps by 2. With it clear, one byte moves (memWrData upper byte 0) and the step is 1.
- R3: Setting control bits 2 (source advances) and 3 (destination advances) together is illegal. The channel sets error bit 7 of its control read-back and performs no transfer. A later control write with a legal setting clears bit 7.
- R4: A transfer is a read cycle (memReq=1, memWe=0) at the source address, followed in the next cycle by a write cycle (memReq=1, memWe=1) at the destination address with the data just read. memReq then drops for at least one cycle. Addresses are 20 bits. A request seen at clock edge k gives the read in the cycle after edge k+1.
- R5: Requests of any kind are ignored while control bit 0 (enable) is 0. Both channels reset with every register at 0.
- R6: The first transfer after enable goes from 0 to 1 loads the counter from the reload register. It also loads the working pointer from the start address of the advancing side. The fixed side always uses its start address.
- R7: In single mode (control bit 4 = 0), a reload value N gives N+1 transfers. After the last one, enable clears itself, the counter reads 0, and further requests move nothing.
- R8: In repeat mode (control bit 4 = 1), an underflow reloads the counter from the reload register, and enable stays set.
- R9: Each counter underflow gives exactly one one-cycle pulse on that channel's irq bit, in the cycle after the write cycle.
- R10: Control bits 6:5 pick the hardware request: 0 falling edge of extReq, 1 either edge of extReq, 2 a high periphReq strobe, 3 none. A trigger write (select 5) requests in every setting. The extReq pins idle high.
- R11: Several requests for one channel that arrive before it is served merge into one transfer.
- R12: Writing enable to 0 drops a pending, not yet served request of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regChan | input | 1 | Channel addressed by write and read-back |
| regSel | input | 3 | Register select |
| regWrData | input | 20 | Register write data |
| regRdData | output | 20 | Combinational read-back of the selected register |
| extReq | input | 2 | External request pins, one per channel |
| periphReq | input | 2 | Peripheral request strobes, one per channel |
| memReq | output | 1 | Bus cycle active |
| memWe | output | 1 | Write cycle when 1, read cycle when 0 |
| memWide | output | 1 | 16-bit unit when 1 |
| memAddr | output | 20 | Byte address of the bus cycle |
| memWrData | output | 16 | Write data |
| memRdData | input | 16 | Read data, valid in the read cycle |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
A request registered at edge k is granted at edge k+1. Its read cycle is visible after that edge, its write cycle one edge later, and the counter, pointer and irq pulse change at the edge that ends the write. The bench runs a behavioural model that advances at every rising edge on the same inputs. It compares the bus and irq outputs at every falling edge, half a cycle after the registers settle. The remaining checks wait for a fixed idle span longer than one complete transfer before reading back registers, memory contents and write counts, so each of those checks falls after the last cycle that could change it.

// File: rtl/dmaCsPkg.sv
package dmaCsPkg;

  localparam int MAX_CH_W = 4;

  // register selects
  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_SRC    = 3'd1;
  localparam logic [2:0] SEL_DST    = 3'd2;
  localparam logic [2:0] SEL_RELOAD = 3'd3;
  localparam logic [2:0] SEL_COUNT  = 3'd4;
  localparam logic [2:0] SEL_TRIG   = 3'd5;
  localparam logic [2:0] SEL_PTR    = 3'd6;

  // hardware request source codes
  localparam logic [1:0] TRG_FALL   = 2'd0;
  localparam logic [1:0] TRG_BOTH   = 2'd1;
  localparam logic [1:0] TRG_PERIPH = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                grant;
    logic [MAX_CH_W-1:0] chan;
    logic                rdPhase;
    logic                wrPhase;
  } ctlStrobes_t;

endpackage

// File: rtl/dmaCsControl.sv
module dmaCsControl
  import dmaCsPkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   readyVec,
  output ctlStrobes_t      ctl,
  output logic             memReq,
  output logic             memWe
);

  phase_e            phase;
  logic [CH_W-1:0]   chanR;
  logic [CH_W-1:0]   pick;
  logic              anyReady;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (readyVec[i]) pick = CH_W'(i);
    end
  end

  assign anyReady = |readyVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      chanR <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (anyReady) begin
          phase <= PH_READ;
          chanR <= pick;
        end
        PH_READ:  phase <= PH_WRITE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.grant   = (phase == PH_IDLE) && anyReady;
    ctl.chan    = MAX_CH_W'((phase == PH_IDLE) ? pick : chanR);
    ctl.rdPhase = (phase == PH_READ);
    ctl.wrPhase = (phase == PH_WRITE);
  end

  assign memReq = (phase != PH_IDLE);
  assign memWe  = (phase == PH_WRITE);

endmodule

// File: rtl/dmaCsDatapath.sv
module dmaCsDatapath
  import dmaCsPkg::*;
#(
  parameter int NCH    = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CH_W-1:0]   regChan,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic [NCH-1:0]    extReq,
  input  logic [NCH-1:0]    periphReq,
  input  ctlStrobes_t       ctl,
  output logic [NCH-1:0]    readyVec,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWide,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [NCH-1:0]    irq
);

  localparam int PAD_CTRL = ADDR_W - 8;
  localparam int PAD_CNT  = ADDR_W - CNT_W;
  localparam int PAD_BYTE = DATA_W - 8;

  logic [CH_W-1:0]   chanSel;
  logic [NCH-1:0]    wideVec;
  logic [ADDR_W-1:0] srcAddrArr [NCH];
  logic [ADDR_W-1:0] dstAddrArr [NCH];
  logic [ADDR_W-1:0] rdArr      [NCH];
  logic [DATA_W-1:0] dataR;

  assign chanSel = ctl.chan[CH_W-1:0];

  for (genvar i = 0; i < NCH; i++) begin : gCh
    logic              en, wide, srcInc, dstInc, rpt, err, armed, pend, extPrev, irqR;
    logic [1:0]        trig;
    logic [ADDR_W-1:0] srcStart, dstStart, ptr, step;
    logic [CNT_W-1:0]  reload, cnt;
    logic              wrThis, serve, finish, legal, hwEvt, evt;

    assign wrThis = regWrEn && (regChan == CH_W'(i));
    assign serve  = ctl.grant && (chanSel == CH_W'(i));
    assign finish = ctl.wrPhase && (chanSel == CH_W'(i));
    assign legal  = !(srcInc && dstInc);
    assign step   = wide ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
      case (trig)
        TRG_FALL:   hwEvt = extPrev && !extReq[i];
        TRG_BOTH:   hwEvt = extPrev ^ extReq[i];
        TRG_PERIPH: hwEvt = periphReq[i];
        default:    hwEvt = 1'b0;
      endcase
    end

    assign evt = en && legal && (hwEvt || (wrThis && regSel == SEL_TRIG));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        en <= 1'b0; wide <= 1'b0; srcInc <= 1'b0; dstInc <= 1'b0;
        rpt <= 1'b0; err <= 1'b0; armed <= 1'b0; pend <= 1'b0;
        extPrev <= 1'b1; irqR <= 1'b0; trig <= '0;
        srcStart <= '0; dstStart <= '0; ptr <= '0;
        reload <= '0; cnt <= '0;
      end else begin
        irqR    <= 1'b0;
        extPrev <= extReq[i];

        if (evt)        pend <= 1'b1;
        else if (serve) pend <= 1'b0;

        if (serve && armed) begin
          cnt   <= reload;
          ptr   <= srcInc ? srcStart : dstStart;
          armed <= 1'b0;
        end

        if (finish) begin
          if (srcInc || dstInc) ptr <= ptr + step;
          if (cnt == '0) begin
            irqR <= 1'b1;
            if (rpt) cnt <= reload;
            else begin
              en   <= 1'b0;
              pend <= 1'b0;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end

        if (wrThis) begin
          case (regSel)
            SEL_CTRL: begin
              en     <= regWrData[0];
              wide   <= regWrData[1];
              srcInc <= regWrData[2];
              dstInc <= regWrData[3];
              rpt    <= regWrData[4];
              trig   <= regWrData[6:5];
              err    <= regWrData[2] && regWrData[3];
              armed  <= regWrData[0] && (armed || !en);
              if (!regWrData[0]) pend <= 1'b0;
            end
            SEL_SRC:    srcStart <= regWrData;
            SEL_DST:    dstStart <= regWrData;
            SEL_RELOAD: reload   <= regWrData[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end

    assign readyVec[i]   = pend && en && legal;
    assign irq[i]        = irqR;
    assign wideVec[i]    = wide;
    assign srcAddrArr[i] = srcInc ? ptr : srcStart;
    assign dstAddrArr[i] = dstInc ? ptr : dstStart;

    always_comb begin
      case (regSel)
        SEL_CTRL:   rdArr[i] = {{PAD_CTRL{1'b0}}, err, trig, rpt, dstInc, srcInc, wide, en};
        SEL_SRC:    rdArr[i] = srcStart;
        SEL_DST:    rdArr[i] = dstStart;
        SEL_RELOAD: rdArr[i] = {{PAD_CNT{1'b0}}, reload};
        SEL_COUNT:  rdArr[i] = {{PAD_CNT{1'b0}}, cnt};
        SEL_PTR:    rdArr[i] = ptr;
        default:    rdArr[i] = '0;
      endcase
    end
  end

  assign regRdData = rdArr[regChan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dataR <= '0;
    else if (ctl.rdPhase) dataR <= memRdData;
  end

  assign memAddr   = ctl.wrPhase ? dstAddrArr[chanSel] : srcAddrArr[chanSel];
  assign memWide   = wideVec[chanSel];
  assign memWrData = memWide ? dataR : {{PAD_BYTE{1'b0}}, dataR[7:0]};

endmodule

// File: rtl/dmaCycleSteal.sv
module dmaCycleSteal
  import dmaCsPkg::*;
#(
  parameter int  NCH    = 2,
  parameter int  ADDR_W = 20,
  parameter int  CNT_W  = 16,
  parameter int  DATA_W = 16,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CH_W-1:0]   regChan,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic [NCH-1:0]    extReq,
  input  logic [NCH-1:0]    periphReq,
  output logic              memReq,
  output logic              memWe,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [NCH-1:0]    irq
);

  ctlStrobes_t    ctl;
  logic [NCH-1:0] readyVec;

  dmaCsControl #(.NCH(NCH), .CH_W(CH_W)) uCtl (
    .clk(clk), .rstN(rstN), .readyVec(readyVec), .ctl(ctl),
    .memReq(memReq), .memWe(memWe)
  );

  dmaCsDatapath #(
    .NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regChan(regChan),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .extReq(extReq), .periphReq(periphReq), .ctl(ctl), .readyVec(readyVec),
    .memAddr(memAddr), .memWide(memWide), .memWrData(memWrData),
    .memRdData(memRdData), .irq(irq)
  );

endmodule

// File: rtl/dmaCycleStealChecker.sv
module dmaCycleStealChecker
  import dmaCsPkg::*;
#(
  parameter int NCH = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                memReq,
  input logic                memWe,
  input logic                memWide,
  input logic [NCH-1:0]      irq,
  input logic                grant,
  input logic [MAX_CH_W-1:0] grantChan,
  input logic [NCH-1:0]      readyVec
);

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> (memReq && memWe));

  assert_bus_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> !memReq);

  assert_unit_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> $stable(memWide));

  assert_chan0_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    (grant && readyVec[0]) |-> (grantChan == '0));

  for (genvar i = 0; i < NCH; i++) begin : gIrq
    assert_irq_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |=> !irq[i]);
  end

endmodule

bind dmaCycleSteal dmaCycleStealChecker #(.NCH(NCH)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memWide(memWide),
  .irq(irq), .grant(ctl.grant), .grantChan(ctl.chan), .readyVec(readyVec)
);

// File: tb/dmaCycleSteal_test.sv
`timescale 1ns/1ps
module dmaCycleSteal_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regChan = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [19:0] regWrData = '0;
  logic [19:0] regRdData;
  logic [1:0]  extReq = 2'b11;
  logic [1:0]  periphReq = 2'b00;
  logic        memReq, memWe, memWide;
  logic [19:0] memAddr;
  logic [15:0] memWrData, memRdData;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int irqCnt0 = 0;
  int irqCnt1 = 0;
  bit done = 0;

  logic [7:0] mem [1024];

  always #5 clk = ~clk;

  dmaCycleSteal uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regChan(regChan),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .extReq(extReq), .periphReq(periphReq), .memReq(memReq), .memWe(memWe),
    .memWide(memWide), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .irq(irq)
  );

  function automatic logic [7:0] memInit(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // bench memory
  logic [9:0] bIdx, bIdx1;
  assign bIdx  = memAddr[9:0];
  assign bIdx1 = bIdx + 10'd1;
  assign memRdData = memWide ? {mem[bIdx1], mem[bIdx]} : {8'h00, mem[bIdx]};

  always @(posedge clk) begin
    if (rstN && memReq && memWe) begin
      mem[bIdx] = memWrData[7:0];
      if (memWide) mem[bIdx1] = memWrData[15:8];
      wrCount++;
    end
    if (rstN && irq[0]) irqCnt0++;
    if (rstN && irq[1]) irqCnt1++;
  end

  // ---------------- behavioural reference model ----------------
  logic        mEn [2], mWide [2], mSi [2], mDi [2], mRpt [2], mErr [2];
  logic        mArm [2], mPend [2], mPrev [2];
  logic [1:0]  mTrig [2];
  logic [19:0] mSrc [2], mDst [2], mPtr [2];
  logic [15:0] mRel [2], mCnt [2];
  int          mPhase = 0;
  int          mChan = 0;
  logic [15:0] mData = '0;
  logic [1:0]  mIrq = '0;

  function automatic logic [19:0] srcA(int c);
    return mSi[c] ? mPtr[c] : mSrc[c];
  endfunction
  function automatic logic [19:0] dstA(int c);
    return mDi[c] ? mPtr[c] : mDst[c];
  endfunction

  always @(posedge clk) begin : refModel
    int g;
    logic [9:0] a;
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mEn[c] = 0; mWide[c] = 0; mSi[c] = 0; mDi[c] = 0; mRpt[c] = 0; mErr[c] = 0;
        mArm[c] = 0; mPend[c] = 0; mPrev[c] = 1; mTrig[c] = 0;
        mSrc[c] = 0; mDst[c] = 0; mPtr[c] = 0; mRel[c] = 0; mCnt[c] = 0;
      end
      mPhase = 0; mChan = 0; mData = 0; mIrq = 0;
    end else begin
      g = -1;
      if (mPhase == 0) begin
        if (mPend[0] && mEn[0] && !(mSi[0] && mDi[0])) g = 0;
        else if (mPend[1] && mEn[1] && !(mSi[1] && mDi[1])) g = 1;
      end
      if (mPhase == 1) begin
        a = srcA(mChan) & 20'h003FF;
        mData = mWide[mChan] ? {mem[a + 10'd1], mem[a]} : {8'h00, mem[a]};
      end
      mIrq = 0;
      for (int c = 0; c < 2; c++) begin
        logic legal, hw, evt, wrC;
        legal = !(mSi[c] && mDi[c]);
        wrC = regWrEn && (regChan == 1'(c));
        case (mTrig[c])
          2'd0: hw = mPrev[c] && !extReq[c];
          2'd1: hw = mPrev[c] != extReq[c];
          2'd2: hw = periphReq[c];
          default: hw = 0;
        endcase
        evt = mEn[c] && legal && (hw || (wrC && regSel == 3'd5));
        if (evt) mPend[c] = 1;
        else if (g == c) mPend[c] = 0;
        if (g == c && mArm[c]) begin
          mCnt[c] = mRel[c];
          mPtr[c] = mSi[c] ? mSrc[c] : mDst[c];
          mArm[c] = 0;
        end
        if (mPhase == 2 && mChan == c) begin
          if (mSi[c] || mDi[c]) mPtr[c] = mPtr[c] + (mWide[c] ? 20'd2 : 20'd1);
          if (mCnt[c] == 0) begin
            mIrq[c] = 1;
            if (mRpt[c]) mCnt[c] = mRel[c];
            else begin mEn[c] = 0; mPend[c] = 0; end
          end else mCnt[c] = mCnt[c] - 16'd1;
        end
        mPrev[c] = extReq[c];
        if (wrC) begin
          case (regSel)
            3'd0: begin
              mArm[c] = regWrData[0] && (mArm[c] || !mEn[c]);
              mEn[c] = regWrData[0]; mWide[c] = regWrData[1];
              mSi[c] = regWrData[2]; mDi[c] = regWrData[3];
              mRpt[c] = regWrData[4]; mTrig[c] = regWrData[6:5];
              mErr[c] = regWrData[2] && regWrData[3];
              if (!regWrData[0]) mPend[c] = 0;
            end
            3'd1: mSrc[c] = regWrData;
            3'd2: mDst[c] = regWrData;
            3'd3: mRel[c] = regWrData[15:0];
            default: ;
          endcase
        end
      end
      case (mPhase)
        0: if (g >= 0) begin mPhase = 1; mChan = g; end
        1: mPhase = 2;
        default: mPhase = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4 memReq", 32'(memReq), 32'(mPhase != 0));
      chk("R9 irq", 32'(irq), 32'(mIrq));
      if (memReq) begin
        chk("R4 memWe", 32'(memWe), 32'(mPhase == 2));
        chk("R4 memAddr", 32'(memAddr), 32'(mPhase == 2 ? dstA(mChan) : srcA(mChan)));
        chk("R2 memWide", 32'(memWide), 32'(mWide[mChan]));
        if (memWe)
          chk("R4 memWrData", 32'(memWrData),
              32'(mWide[mChan] ? mData : {8'h00, mData[7:0]}));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, logic [2:0] sel, logic [19:0] d);
    regWrEn = 1; regChan = 1'(ch); regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(int ch, logic [2:0] sel, output logic [19:0] v);
    regChan = 1'(ch); regSel = sel;
    #1;
    v = regRdData;
  endtask

  task automatic waitRead(output logic [19:0] addr);
    addr = '1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (memReq && !memWe) begin addr = memAddr; break; end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [19:0] v;
    int base;
    for (int a = 0; a < 1024; a++) mem[a] = memInit(a);
    idle(3);
    rstN = 1;
    idle(2);

    // reset state
    rd(0, 3'd0, v); chk("R5 reset ctrl ch0", 32'(v), 0);
    rd(1, 3'd0, v); chk("R5 reset ctrl ch1", 32'(v), 0);
    chk("R4 reset memReq", 32'(memReq), 0);

    // software trigger, single mode, byte units, source advancing
    wr(0, 3'd1, 20'h00100);
    wr(0, 3'd2, 20'h00300);
    wr(0, 3'd3, 20'd2);
    wr(0, 3'd0, 20'h65);
    for (int k = 0; k < 3; k++) begin wr(0, 3'd5, 0); idle(6); end
    rd(0, 3'd0, v); chk("R7 enable self-clear", 32'(v), 32'h64);
    rd(0, 3'd4, v); chk("R7 counter after underflow", 32'(v), 0);
    rd(0, 3'd6, v); chk("R6 R2 byte pointer", 32'(v), 32'h103);
    chk("R6 last byte moved", 32'(mem[10'h300]), 32'(memInit(32'h102)));
    chk("R9 irq count ch0", irqCnt0, 1);
    chk("R10 software trigger moves", wrCount, 3);
    base = wrCount;
    wr(0, 3'd5, 0); idle(6);
    chk("R7 request after stop ignored", wrCount - base, 0);

    // peripheral strobe, repeat mode, 16-bit, destination advancing
    wr(1, 3'd1, 20'hA0040);
    wr(1, 3'd2, 20'h00200);
    wr(1, 3'd3, 20'd1);
    wr(1, 3'd0, 20'h5B);
    base = wrCount;
    for (int k = 0; k < 5; k++) begin
      periphReq[1] = 1; @(negedge clk); periphReq[1] = 0; idle(6);
    end
    chk("R10 peripheral strobe moves", wrCount - base, 5);
    chk("R8 irq count ch1", irqCnt1, 2);
    rd(1, 3'd0, v); chk("R8 enable kept", 32'(v), 32'h5B);
    rd(1, 3'd4, v); chk("R8 counter reloaded", 32'(v), 0);
    rd(1, 3'd6, v); chk("R2 word pointer", 32'(v), 32'h20A);
    chk("R2 low byte", 32'(mem[10'h208]), 32'(memInit(32'h40)));
    chk("R2 high byte", 32'(mem[10'h209]), 32'(memInit(32'h41)));

    // priority with simultaneous pin events
    wr(0, 3'd3, 20'd10);
    wr(0, 3'd0, 20'h15);
    wr(1, 3'd0, 20'h3B);
    idle(2);
    extReq = 2'b00;
    waitRead(v); chk("R1 channel 0 first", 32'(v), 32'h00100);
    waitRead(v); chk("R1 channel 1 second", 32'(v), 32'hA0040);
    idle(6);
    base = wrCount;
    extReq[1] = 1; idle(6);
    chk("R10 rising edge on both-edge channel", wrCount - base, 1);
    base = wrCount;
    extReq[0] = 1; idle(6);
    chk("R10 rising edge on falling-edge channel", wrCount - base, 0);

    // merging of requests
    base = wrCount;
    wr(0, 3'd5, 0);
    wr(1, 3'd5, 0);
    wr(1, 3'd5, 0);
    idle(10);
    chk("R11 merged requests", wrCount - base, 2);

    // disable drops a pending request
    base = wrCount;
    wr(1, 3'd5, 0);
    wr(0, 3'd5, 0);
    wr(0, 3'd0, 20'h14);
    idle(8);
    chk("R12 pending dropped", wrCount - base, 1);
    rd(0, 3'd0, v); chk("R12 enable cleared", 32'(v), 32'h14);
    base = wrCount;
    wr(0, 3'd5, 0); periphReq[0] = 1; @(negedge clk); periphReq[0] = 0;
    idle(6);
    chk("R5 disabled channel ignores requests", wrCount - base, 0);

    // illegal direction setting
    wr(1, 3'd0, 20'h6D);
    rd(1, 3'd0, v); chk("R3 error bit", 32'(v), 32'hED);
    base = wrCount;
    wr(1, 3'd5, 0); idle(6);
    chk("R3 no transfer", wrCount - base, 0);
    wr(1, 3'd0, 20'h69);
    rd(1, 3'd0, v); chk("R3 error cleared", 32'(v), 32'h69);
    wr(1, 3'd5, 0); idle(6);
    chk("R3 legal again moves", wrCount - base, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule